// File: doc/BRIEF.md
# Terminal-Side Modem Handshake Sequencer

This block runs the control-line procedure that a data terminal follows on a serial link with a modem. It places or accepts a call by raising DTR. It waits for the modem to report data-set-ready and then carrier. When asked to send, it raises RTS and opens a data window once CTS answers. It then takes the link down in a fixed order: RTS drops first, then the block waits for CTS to fall, then for carrier and data-set-ready to clear, and only then drops DTR.

The local transmitter asks the block before it starts each character. A start is granted only while the link is in its data phase and the synchronised CTS is high. A character that has already started is never cut off. Every waiting phase is guarded by a cycle-count limit set at a port. If a wait runs past that limit, the call is abandoned with both control lines low and a timeout flag set. A drop of the modem's connection lines while the call is up sets a carrier-loss flag and starts the ordered teardown.

Top module: `dte_link_seq`

## Requirements
- R1: After reset, `phase` is 0 and `dtr_out`, `rts_out`, `tx_permit`, `tx_char_go`, `timeout_flag` and `carrier_lost` are all low. Phase codes: 0 idle, 1 wait for DSR, 2 wait for CD, 3 connected, 4 wait for CTS, 5 data, 6 wait for CTS to fall, 7 wait for DSR and CD to fall. `dtr_out` is high in every phase except 0. `rts_out` is high only in phases 4 and 5.
- R2: In phase 0, `call_orig` high moves the block to phase 1 on the next clock, which raises DTR.
- R3: In phase 0 with `answer_en` high, a synchronised RI high moves the block to phase 1. With `answer_en` low, RI is ignored and the block stays in phase 0.
- R4: Phase 1 moves to phase 2 only on synchronised DSR. CD is ignored while in phase 1. Phase 2 moves to phase 3 on synchronised CD.
- R5: In phase 3, `send_req` moves the block to phase 4, which raises RTS. Phase 4 moves to phase 5 on synchronised CTS.
- R6: `tx_permit` is high exactly when the block is in phase 5 and synchronised CTS is high. `tx_char_go` equals `tx_char_req` AND `tx_permit`, with no register delay.
- R7: `hangup_req` in phase 3 or phase 4 moves the block to phase 6. In phase 5, `hangup_req` moves the block to phase 6 only in a cycle where `tx_char_active` is low.
- R8: Phase 6 moves to phase 7 once synchronised CTS is low. Phase 7 moves to phase 0 once both synchronised DSR and CD are low, and DTR drops at that point.
- R9: In phases 3, 4 and 5, a low synchronised DSR or CD moves the block to phase 6 and sets `carrier_lost`. This check has priority over hangup and send.
- R10: Phases 1, 2, 4, 6 and 7 are timed waits. If a timed phase has been held for `wait_limit`+1 cycles without its exit condition, the next clock moves the block to phase 0 and sets `timeout_flag`.
- R11: `timeout_flag` and `carrier_lost` stay set until the block leaves phase 0 for phase 1.
- R12: RI, DSR, CD and CTS pass through a two-stage synchroniser. A level change at a pin first affects a state decision at the third clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_orig | input | 1 | Request to place a call |
| answer_en | input | 1 | Allow incoming calls to be answered |
| send_req | input | 1 | Request to enter the data phase |
| hangup_req | input | 1 | Request an ordered disconnect |
| tx_char_req | input | 1 | Local transmitter wants to start a character |
| tx_char_active | input | 1 | A character is being shifted out |
| ri_in | input | 1 | Ring indicator from the modem |
| dsr_in | input | 1 | Data set ready from the modem |
| cd_in | input | 1 | Carrier detect from the modem |
| cts_in | input | 1 | Clear to send from the modem |
| wait_limit | input | TMO_W | Timeout limit for timed phases, in cycles |
| dtr_out | output | 1 | Data terminal ready to the modem |
| rts_out | output | 1 | Request to send to the modem |
| tx_permit | output | 1 | Character starts are allowed |
| tx_char_go | output | 1 | Grant to start the requested character |
| phase | output | 3 | Current phase code |
| timeout_flag | output | 1 | A timed wait expired |
| carrier_lost | output | 1 | The link dropped during a call |

## Verification
The hardest case to reach is the overlap of a link failure with a later timeout. Carrier drops during the data phase while the modem keeps CTS high, so the teardown stalls in phase 6 until its wait limit runs out. The stimulus builds a full call with a short limit, then removes CD alone. The bench then watches the block record both flags and return to idle. A second hard case is a hangup held while a character is in flight after CTS has already fallen. The stimulus holds `tx_char_active` through that window and confirms that no new start is granted and that RTS stays up until the character ends.

// File: rtl/dte_link_pkg.sv
package dte_link_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_WDSR    = 3'd1,
    PH_WCD     = 3'd2,
    PH_CONN    = 3'd3,
    PH_WCTS    = 3'd4,
    PH_DATA    = 3'd5,
    PH_CTSOFF  = 3'd6,
    PH_LINEOFF = 3'd7
  } phase_e;

  localparam int MODEM_LINES = 4;
  localparam int LN_RI  = 0;
  localparam int LN_DSR = 1;
  localparam int LN_CD  = 2;
  localparam int LN_CTS = 3;

  function automatic logic is_timed(input phase_e p);
    return (p == PH_WDSR) || (p == PH_WCD) || (p == PH_WCTS) ||
           (p == PH_CTSOFF) || (p == PH_LINEOFF);
  endfunction

endpackage

// File: rtl/dte_sync.sv
module dte_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/dte_wait_timer.sv
module dte_wait_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_wait,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         expired
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = restart || in_wait;
    cnt_d  = restart ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = in_wait && (cnt_q == limit);

endmodule

// File: rtl/dte_link_fsm.sv
module dte_link_fsm
  import dte_link_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   call_orig,
  input  logic   answer_en,
  input  logic   send_req,
  input  logic   hangup_req,
  input  logic   tx_char_active,
  input  logic   ri_s,
  input  logic   dsr_s,
  input  logic   cd_s,
  input  logic   cts_s,
  input  logic   expired,
  output logic   in_wait,
  output logic   restart,
  output phase_e cur,
  output logic   tmo_q,
  output logic   loss_q
);

  phase_e nxt;
  logic   set_tmo, set_loss, clr_flags, link_down;

  assign link_down = !dsr_s || !cd_s;
  assign in_wait   = is_timed(cur);

  always_comb begin
    nxt       = cur;
    set_tmo   = 1'b0;
    set_loss  = 1'b0;
    clr_flags = 1'b0;
    case (cur)
      PH_IDLE: begin
        if (call_orig || (answer_en && ri_s)) begin
          nxt       = PH_WDSR;
          clr_flags = 1'b1;
        end
      end
      PH_WDSR:  if (dsr_s) nxt = PH_WCD;
      PH_WCD:   if (cd_s)  nxt = PH_CONN;
      PH_CONN: begin
        if (link_down) begin
          nxt      = PH_CTSOFF;
          set_loss = 1'b1;
        end else if (hangup_req) begin
          nxt = PH_CTSOFF;
        end else if (send_req) begin
          nxt = PH_WCTS;
        end
      end
      PH_WCTS: begin
        if (link_down) begin
          nxt      = PH_CTSOFF;
          set_loss = 1'b1;
        end else if (hangup_req) begin
          nxt = PH_CTSOFF;
        end else if (cts_s) begin
          nxt = PH_DATA;
        end
      end
      PH_DATA: begin
        if (link_down) begin
          nxt      = PH_CTSOFF;
          set_loss = 1'b1;
        end else if (hangup_req && !tx_char_active) begin
          nxt = PH_CTSOFF;
        end
      end
      PH_CTSOFF:  if (!cts_s) nxt = PH_LINEOFF;
      PH_LINEOFF: if (!dsr_s && !cd_s) nxt = PH_IDLE;
    endcase
    if (expired && (nxt == cur)) begin
      nxt     = PH_IDLE;
      set_tmo = 1'b1;
    end
  end

  assign restart = (nxt != cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur    <= PH_IDLE;
      tmo_q  <= 1'b0;
      loss_q <= 1'b0;
    end else begin
      cur <= nxt;
      if (clr_flags || set_tmo) begin
        tmo_q <= set_tmo;
      end
      if (clr_flags || set_loss) begin
        loss_q <= set_loss;
      end
    end
  end

endmodule

// File: rtl/dte_link_seq.sv
module dte_link_seq
  import dte_link_pkg::*;
#(
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             call_orig,
  input  logic             answer_en,
  input  logic             send_req,
  input  logic             hangup_req,
  input  logic             tx_char_req,
  input  logic             tx_char_active,
  input  logic             ri_in,
  input  logic             dsr_in,
  input  logic             cd_in,
  input  logic             cts_in,
  input  logic [TMO_W-1:0] wait_limit,
  output logic             dtr_out,
  output logic             rts_out,
  output logic             tx_permit,
  output logic             tx_char_go,
  output logic [2:0]       phase,
  output logic             timeout_flag,
  output logic             carrier_lost
);

  logic [MODEM_LINES-1:0] raw_lines, sync_lines;
  logic                   in_wait, restart, expired;
  phase_e                 cur;

  always_comb begin
    raw_lines         = '0;
    raw_lines[LN_RI]  = ri_in;
    raw_lines[LN_DSR] = dsr_in;
    raw_lines[LN_CD]  = cd_in;
    raw_lines[LN_CTS] = cts_in;
  end

  dte_sync #(.W(MODEM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (raw_lines),
    .dout (sync_lines)
  );

  dte_wait_timer #(.W(TMO_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_wait(in_wait),
    .restart(restart),
    .limit  (wait_limit),
    .expired(expired)
  );

  dte_link_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .call_orig     (call_orig),
    .answer_en     (answer_en),
    .send_req      (send_req),
    .hangup_req    (hangup_req),
    .tx_char_active(tx_char_active),
    .ri_s          (sync_lines[LN_RI]),
    .dsr_s         (sync_lines[LN_DSR]),
    .cd_s          (sync_lines[LN_CD]),
    .cts_s         (sync_lines[LN_CTS]),
    .expired       (expired),
    .in_wait       (in_wait),
    .restart       (restart),
    .cur           (cur),
    .tmo_q         (timeout_flag),
    .loss_q        (carrier_lost)
  );

  assign phase      = cur;
  assign dtr_out    = (cur != PH_IDLE);
  assign rts_out    = (cur == PH_WCTS) || (cur == PH_DATA);
  assign tx_permit  = (cur == PH_DATA) && sync_lines[LN_CTS];
  assign tx_char_go = tx_char_req && tx_permit;

endmodule

// File: rtl/dte_link_chk.sv
module dte_link_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dtr_out,
  input logic       rts_out,
  input logic       tx_permit,
  input logic       tx_char_go,
  input logic       tx_char_req,
  input logic [2:0] phase,
  input logic       timeout_flag,
  input logic       carrier_lost
);

  // R5
  rts_needs_dtr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rts_out |-> dtr_out);

  // R6
  go_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_char_go |-> (tx_permit && tx_char_req));

  // R6
  permit_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_permit |-> (phase == 3'd5 && rts_out));

  // R10
  tmo_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> (phase == 3'd0 && !dtr_out));

  // R9
  loss_drops_rts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier_lost) |-> (!rts_out && phase == 3'd6));

  // R8
  dtr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtr_out) |-> ($past(phase) == 3'd7 || timeout_flag));

endmodule

bind dte_link_seq dte_link_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dtr_out     (dtr_out),
  .rts_out     (rts_out),
  .tx_permit   (tx_permit),
  .tx_char_go  (tx_char_go),
  .tx_char_req (tx_char_req),
  .phase       (phase),
  .timeout_flag(timeout_flag),
  .carrier_lost(carrier_lost)
);

// File: tb/sim_dte_link_seq.sv
module sim_dte_link_seq;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, call_orig, answer_en, send_req, hangup_req;
  logic        tx_char_req, tx_char_active, ri_in, dsr_in, cd_in, cts_in;
  logic [15:0] wait_limit;
  logic        dtr_out, rts_out, tx_permit, tx_char_go, timeout_flag, carrier_lost;
  logic [2:0]  phase;

  dte_link_seq u0 (
    .clk(clk), .rst_n(rst_n), .call_orig(call_orig), .answer_en(answer_en),
    .send_req(send_req), .hangup_req(hangup_req), .tx_char_req(tx_char_req),
    .tx_char_active(tx_char_active), .ri_in(ri_in), .dsr_in(dsr_in),
    .cd_in(cd_in), .cts_in(cts_in), .wait_limit(wait_limit),
    .dtr_out(dtr_out), .rts_out(rts_out), .tx_permit(tx_permit),
    .tx_char_go(tx_char_go), .phase(phase), .timeout_flag(timeout_flag),
    .carrier_lost(carrier_lost)
  );

  int    vecs = 0;
  int    bad  = 0;
  bit    done = 0;
  string req  = "R1";

  // reference model state
  int m_st, m_cnt, m_tmo, m_loss;
  int s1[4];
  int s2[4];

  task automatic chk(string nm, int act, int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic compare();
    int e_permit;
    e_permit = (m_st == 5 && s2[3] != 0) ? 1 : 0;
    chk("phase", int'(phase), m_st);
    chk("dtr", int'(dtr_out), (m_st != 0) ? 1 : 0);
    chk("rts", int'(rts_out), (m_st == 4 || m_st == 5) ? 1 : 0);
    chk("permit", int'(tx_permit), e_permit);
    chk("go", int'(tx_char_go), (e_permit != 0 && tx_char_req) ? 1 : 0);
    chk("timeout_flag", int'(timeout_flag), m_tmo);
    chk("carrier_lost", int'(carrier_lost), m_loss);
  endtask

  task automatic model_step();
    int nst, ri, dsr, cd, cts, down, timed;
    ri = s2[0]; dsr = s2[1]; cd = s2[2]; cts = s2[3];
    down  = (dsr == 0 || cd == 0) ? 1 : 0;
    timed = (m_st == 1 || m_st == 2 || m_st == 4 || m_st == 6 || m_st == 7) ? 1 : 0;
    nst = m_st;
    case (m_st)
      0: if (call_orig || (answer_en && ri != 0)) begin nst = 1; m_tmo = 0; m_loss = 0; end
      1: if (dsr != 0) nst = 2;
      2: if (cd != 0) nst = 3;
      3: if (down != 0) begin nst = 6; m_loss = 1; end
         else if (hangup_req) nst = 6;
         else if (send_req) nst = 4;
      4: if (down != 0) begin nst = 6; m_loss = 1; end
         else if (hangup_req) nst = 6;
         else if (cts != 0) nst = 5;
      5: if (down != 0) begin nst = 6; m_loss = 1; end
         else if (hangup_req && !tx_char_active) nst = 6;
      6: if (cts == 0) nst = 7;
      7: if (dsr == 0 && cd == 0) nst = 0;
      default: nst = 0;
    endcase
    if (timed != 0 && nst == m_st && m_cnt == int'(wait_limit)) begin
      nst = 0;
      m_tmo = 1;
    end
    if (nst != m_st) m_cnt = 0;
    else if (timed != 0) m_cnt++;
    m_st = nst;
    for (int i = 0; i < 4; i++) s2[i] = s1[i];
    s1[0] = ri_in; s1[1] = dsr_in; s1[2] = cd_in; s1[3] = cts_in;
  endtask

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      #1;
      compare();
    end
  endtask

  initial begin
    rst_n = 1'b0; call_orig = 0; answer_en = 0; send_req = 0; hangup_req = 0;
    tx_char_req = 0; tx_char_active = 0; ri_in = 0; dsr_in = 0; cd_in = 0;
    cts_in = 0; wait_limit = 16'd20;
    m_st = 0; m_cnt = 0; m_tmo = 0; m_loss = 0;
    for (int i = 0; i < 4; i++) begin s1[i] = 0; s2[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    req = "R1"; compare();

    // R2 originate; R12 latency throughout
    req = "R2"; call_orig = 1; cyc(1); call_orig = 0; cyc(3);
    // R4: CD before DSR ignored, then DSR
    req = "R4"; cd_in = 1; cyc(4); dsr_in = 1; cyc(5);
    // R5
    req = "R5"; send_req = 1; cyc(3); send_req = 0; cts_in = 1; cyc(4);
    // R6: grant, then CTS falls mid-character
    req = "R6"; tx_char_req = 1; cyc(2); cts_in = 0; tx_char_active = 1; cyc(4);
    cts_in = 1; cyc(3); tx_char_req = 0;
    // R7: hangup held while a character finishes
    req = "R7"; hangup_req = 1; cyc(5); tx_char_active = 0; cyc(2); hangup_req = 0;
    // R8: ordered release
    req = "R8"; cyc(3); cts_in = 0; cyc(4); dsr_in = 0; cyc(3); cd_in = 0; cyc(4);
    // R3: ring ignored, then answered
    req = "R3"; ri_in = 1; cyc(5); answer_en = 1; cyc(4); ri_in = 0; answer_en = 0;
    // R10: timeout waiting for DSR
    req = "R10"; wait_limit = 16'd6; cyc(10);
    // R11: flag held, then cleared on new call
    req = "R11"; cyc(3); call_orig = 1; cyc(1); call_orig = 0; cyc(2);
    // R9: carrier loss in data, then teardown stalls and times out
    req = "R9"; dsr_in = 1; cd_in = 1; cyc(6); send_req = 1; cts_in = 1; cyc(6);
    send_req = 0; cd_in = 0; cyc(4);
    req = "R10"; cyc(10);
    dsr_in = 0; cts_in = 0; cyc(3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

endmodule